// File: doc/BRIEF.md
# Device Identifier Serial Reader

This block fetches the unique identifier that a device carries in one-time fuses. The identifier can only be reached through a read-only serial port built around a shift register. The controller first drives a one-cycle load strobe, which copies the fused value in parallel into the port's shift register. It then raises a shift enable and samples the port's serial output once per clock, collecting exactly one identifier width of bits. Each bit enters at the least significant end of the word, so the first bit taken is the most significant bit of the result. The bit fed back into the port's shift input is held at zero.

A read begins only when the downstream consumer holds ready high. Once the whole word is assembled, the controller presents it with a valid flag. Data and valid stay frozen until the consumer samples ready together with valid. The controller then drops valid and goes back to idle. The identifier width is a parameter, which covers both the 57-bit and the 96-bit identifier generations.

Top module: `uid_serial_reader`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, the load strobe, shift enable and valid flag are all low.
- R2: A load strobe is issued only on the clock edge after a cycle in which ready was high while the controller was idle. While ready stays low in idle, neither load nor shift is asserted.
- R3: The load strobe lasts exactly one clock. Shift is asserted in the cycle right after it, and load and shift are never high in the same cycle.
- R4: After each load, shift stays high for exactly ID_WIDTH consecutive cycles and then falls.
- R5: The serial output is sampled on every clock edge where shift is high. The first sample becomes bit ID_WIDTH-1 of the word and the last sample becomes bit 0, so the presented word equals the identifier that was loaded.
- R6: Valid rises on the clock edge that takes the last sample. While valid is high and ready is low, valid stays high and the data does not change.
- R7: On the edge where valid and ready are both high, the word is accepted. Valid is low in the following cycle, and the controller is idle again, so it starts nothing while ready is low.
- R8: The serial input driven back into the port is always 0.
- R9: The same behaviour holds for an ID_WIDTH of 57 and of 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller and the identifier port |
| rst | input | 1 | Synchronous active-high reset |
| id_load_o | output | 1 | One-cycle strobe that copies the fused identifier into the port shift register |
| id_shift_o | output | 1 | Shift enable for the port shift register |
| id_sin_o | output | 1 | Bit shifted into the port shift register (held at 0) |
| id_sout_i | input | 1 | Serial output of the port shift register |
| word_data_o | output | ID_WIDTH | Assembled identifier |
| word_valid_o | output | 1 | Identifier on word_data_o is complete |
| word_ready_i | input | 1 | Consumer ready; starts a read in idle and accepts the word when valid |

## Verification
The bench targets the bit order with patterns such as a lone most significant bit, alternating bits, all ones and all zeros. A reader that sampled one cycle early or late, or that shifted the wrong way, would present a rotated or reversed word. Each read also checks that shift follows load directly and lasts exactly the identifier width. An off-by-one counter would show up there as one shift too many or too few. The bench holds ready low for several cycles while valid is high, to catch data or valid that move before acceptance. After acceptance it holds ready low again, to catch a controller that restarts a read by itself. Both widths run through the same sequence.

// File: rtl/uid_rd_pkg.sv
package uid_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOAD    = 2'd1,
    ST_SHIFT   = 2'd2,
    ST_PRESENT = 2'd3
  } uid_state_e;

endpackage

// File: rtl/uid_bit_counter.sv
module uid_bit_counter #(
  parameter int WIDTH = 57
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic step,
  output logic last
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (arm) begin
      count_q <= TOP;
    end else if (step && (count_q != '0)) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign last = (count_q == '0);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= TOP);

  // R4
  cnt_arm_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (count_q == TOP));

endmodule

// File: rtl/uid_word_assembler.sv
module uid_word_assembler #(
  parameter int WIDTH = 57
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] word_q;

  generate
    if (WIDTH > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '0;
        end else if (capture) begin
          word_q <= {word_q[WIDTH-2:0], bit_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '0;
        end else if (capture) begin
          word_q <= bit_in;
        end
      end
    end
  endgenerate

  assign word_o = word_q;

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(word_q));

  // R5
  word_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> (word_q[0] == $past(bit_in)));

endmodule

// File: rtl/uid_port_sequencer.sv
module uid_port_sequencer
  import uid_rd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ready,
  input  logic last,
  output logic load_o,
  output logic shift_o,
  output logic valid_o,
  output logic arm_o
);
  uid_state_e state_q, state_d;
  logic load_q, shift_q, valid_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (ready) state_d = ST_LOAD;
      ST_LOAD:    state_d = ST_SHIFT;
      ST_SHIFT:   if (last) state_d = ST_PRESENT;
      ST_PRESENT: if (ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      load_q  <= 1'b0;
      shift_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= (state_d == ST_LOAD);
      shift_q <= (state_d == ST_SHIFT);
      valid_q <= (state_d == ST_PRESENT);
    end
  end

  assign load_o  = load_q;
  assign shift_o = shift_q;
  assign valid_o = valid_q;
  assign arm_o   = (state_q == ST_LOAD);

  // R3
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_q && shift_q));

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    load_q |=> (!load_q && shift_q));

  // R2
  load_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(load_q) |-> $past(ready));

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready) |=> valid_q);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ready) |=> !valid_q);

  // R6
  valid_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(shift_q));

endmodule

// File: rtl/uid_serial_reader.sv
module uid_serial_reader #(
  parameter int ID_WIDTH = 57
) (
  input  logic                clk,
  input  logic                rst,
  output logic                id_load_o,
  output logic                id_shift_o,
  output logic                id_sin_o,
  input  logic                id_sout_i,
  output logic [ID_WIDTH-1:0] word_data_o,
  output logic                word_valid_o,
  input  logic                word_ready_i
);
  localparam int RUN_W = $clog2(ID_WIDTH + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(ID_WIDTH);

  logic arm;
  logic last;

  uid_port_sequencer u_seq (
    .clk     (clk),
    .rst     (rst),
    .ready   (word_ready_i),
    .last    (last),
    .load_o  (id_load_o),
    .shift_o (id_shift_o),
    .valid_o (word_valid_o),
    .arm_o   (arm)
  );

  uid_bit_counter #(.WIDTH(ID_WIDTH)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .arm  (arm),
    .step (id_shift_o),
    .last (last)
  );

  uid_word_assembler #(.WIDTH(ID_WIDTH)) u_asm (
    .clk     (clk),
    .rst     (rst),
    .capture (id_shift_o),
    .bit_in  (id_sout_i),
    .word_o  (word_data_o)
  );

  assign id_sin_o = 1'b0;

  // run-length tracker used only by the shift-window assertion
  logic [RUN_W-1:0] shift_run_q;
  always_ff @(posedge clk) begin
    if (rst || id_load_o) begin
      shift_run_q <= '0;
    end else if (id_shift_o && (shift_run_q != RUN_FULL)) begin
      shift_run_q <= shift_run_q + 1'b1;
    end
  end

  // R4
  shift_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(id_shift_o) |-> (shift_run_q == RUN_FULL));

  // R6
  data_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid_o && !word_ready_i) |=> $stable(word_data_o));

endmodule

// File: tb/uid_serial_reader_bench.sv
`timescale 1ns/1ps

module uid_reader_harness #(
  parameter int WIDTH   = 57,
  parameter int DRV_DLY = 2
) (
  input logic clk,
  input logic rst
);
  logic             load, shift, sin, sout, valid, ready;
  logic [WIDTH-1:0] data;
  logic [WIDTH-1:0] fuse_val = '0;
  logic [WIDTH-1:0] port_sr  = '0;

  // behavioural identifier port
  always_ff @(posedge clk) begin
    if (load) port_sr <= fuse_val;
    else if (shift) port_sr <= {port_sr[WIDTH-2:0], sin};
  end
  assign sout = port_sr[WIDTH-1];

  uid_serial_reader #(.ID_WIDTH(WIDTH)) u_uid_serial_reader (
    .clk          (clk),
    .rst          (rst),
    .id_load_o    (load),
    .id_shift_o   (shift),
    .id_sin_o     (sin),
    .id_sout_i    (sout),
    .word_data_o  (data),
    .word_valid_o (valid),
    .word_ready_i (ready)
  );

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s W=%0d %s: actual %h expected %h", req, WIDTH, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(DRV_DLY);
  endtask

  // monitor: scoreboard pop and per-read protocol checks
  logic prev_load = 1'b0, prev_shift = 1'b0, prev_ready = 1'b0;
  int   shift_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (valid && ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected word", 128'(data), 128'(0));
        end else begin
          logic [WIDTH-1:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R5 R9", "word", 128'(data), 128'(e));
        end
      end
      if (load && shift) chk(1'b0, "R3", "load with shift", 128'(1), 128'(0));
      if (load && !prev_load) begin
        chk(prev_ready, "R2", "ready before load", 128'(prev_ready), 128'(1));
        chk(sin == 1'b0, "R8", "serial input", 128'(sin), 128'(0));
      end
      if (prev_load) begin
        chk(!load && shift, "R3", "load then shift", 128'({load, shift}), 128'(2'b01));
      end
      if (shift) shift_run++;
      if (prev_shift && !shift) begin
        chk(shift_run == WIDTH, "R4", "shift cycles", 128'(shift_run), 128'(WIDTH));
        chk(valid, "R6", "valid after last sample", 128'(valid), 128'(1));
        shift_run = 0;
      end
      prev_load  = load;
      prev_shift = shift;
      prev_ready = ready;
    end
  end

  task automatic init();
    ready = 1'b0;
  endtask

  task automatic check_reset();
    chk({load, shift, valid} == 3'b000, "R1", "outputs in reset",
        128'({load, shift, valid}), 128'(0));
  endtask

  task automatic check_idle(input int n);
    bit busy;
    busy = 1'b0;
    ready = 1'b0;
    for (int i = 0; i < n; i++) begin
      step();
      if (load || shift || valid) busy = 1'b1;
    end
    chk(!busy, "R2", "activity with ready low", 128'(busy), 128'(0));
  endtask

  // driver: push expected word, run one read, hold acceptance for hold cycles
  task automatic do_read(input logic [WIDTH-1:0] val, input int hold);
    logic [WIDTH-1:0] snap;
    bit moved;
    fuse_val = val;
    exp_q.push_back(val);
    ready = 1'b1;
    do step(); while (!load);
    if (hold > 0) ready = 1'b0;
    do step(); while (!valid);
    if (hold > 0) begin
      snap  = data;
      moved = 1'b0;
      for (int i = 0; i < hold; i++) begin
        step();
        if (!valid || data != snap) moved = 1'b1;
      end
      chk(!moved, "R6", "hold while not ready", 128'(data), 128'(snap));
      ready = 1'b1;
    end
    step();
    ready = 1'b0;
    chk(!valid, "R7", "valid after accept", 128'(valid), 128'(0));
    check_idle(4);
  endtask

  task automatic check_drained();
    chk(exp_q.size() == 0, "R5", "words outstanding", 128'(exp_q.size()), 128'(0));
  endtask
endmodule

module uid_serial_reader_bench;
  localparam time CLK_PERIOD = 8;
  localparam int  WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   wd_err = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uid_reader_harness #(.WIDTH(57), .DRV_DLY(2)) h57 (.clk(clk), .rst(rst));
  uid_reader_harness #(.WIDTH(96), .DRV_DLY(2)) h96 (.clk(clk), .rst(rst));

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors",
             h57.checks + h96.checks + 1, h57.errors + h96.errors + wd_err);
    $finish;
  endtask

  initial begin
    h57.init();
    h96.init();
    repeat (3) @(posedge clk);
    #2;
    // R1: reset holds outputs low
    h57.check_reset();
    h96.check_reset();
    @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk);
    #2;
    h57.check_reset();
    h96.check_reset();
    // R2: no read without ready
    h57.check_idle(20);
    h96.check_idle(20);
    // R5 R9: bit order across patterns, both widths
    h57.do_read({1'b1, 56'h23456789ABCDEF}, 0);
    h57.do_read({1'b1, 56'h0}, 5);
    h57.do_read(57'h0AAAAAAAAAAAAAA, 3);
    h57.do_read({57{1'b1}}, 0);
    h57.do_read(57'h0, 2);
    h96.do_read(96'hDEADBEEF0123456789ABCDEF, 0);
    h96.do_read(96'h800000000000000000000001, 6);
    h96.do_read({96{1'b1}}, 1);
    h96.do_read(96'h0, 0);
    h57.check_drained();
    h96.check_drained();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      wd_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule